// File: doc/BRIEF.md
# SDRAM Concurrent Auto-Precharge Bank Sequencer

This block is the device-side command sequencer of a four-bank synchronous DRAM. It takes one decoded command per clock (activate, read, write, precharge or no-op) and the bank, column and DQM inputs that come with it. It keeps a state machine for each bank and runs the single read burst and the single write burst that may be on the data bus. It reports read data slots and write acceptance slots, each with its bank and column. The memory array itself, refresh, power-down and electrical timing are outside the block.

The main feature is concurrent auto precharge. An access to a different bank may cut off a burst whose bank has auto precharge pending. The cut-off bank then starts precharging on the clock the new access is registered. For reads, the new bank's data takes over the bus one CAS latency later. A write-burst-mode input shortens every write to one column and leaves reads unchanged.

The two data slot outputs work as valid-only streams. There is no ready input and no back-pressure: the consumer must take the beat in every cycle where `rd_valid_o` or `wr_acc_o` is high. Mode inputs (`bl_code_i`, `cl_i`, `wbm_i`) are expected to stay stable while a burst is running.

Top module: `sdram_ap_sequencer`

## Requirements
- R1: After reset all four bank states read 0 (idle), and `rd_valid_o`, `wr_acc_o` and `viol_o` are 0.
- R2: `bank_state_o[3*b+:3]` holds bank b's state, coded idle=0, active=1, reading=2, writing=3, write-back=4, precharging=5. Activate (cmd 1) moves an idle bank to active. Read (cmd 2) or write (cmd 3) to an active, reading or writing bank moves it to reading or writing. Precharge (cmd 4) moves any bank that is not idle or precharging to precharging. Command code 0 is no-op.
- R3: A read registered at clock T gives its first data slot (`rd_valid_o`=1) in the cycle after clock T+CL, where CL is `cl_i` (1 to 3; 0 acts as 1). It gives 2^`bl_code_i` consecutive slots (codes 0..3 give 1, 2, 4, 8).
- R4: Within a burst, the column goes up by one each beat and wraps inside the block of burst-length size that holds the start column.
- R5: With `wbm_i`=1, a write gives exactly one accept slot. Reads keep the programmed burst length.
- R6: A write registered at clock T gives its first accept slot (`wr_acc_o`=1, column `col_i`) in the cycle right after T. With `wbm_i`=0 the write runs for the full burst length.
- R7: A read to bank m while bank n is reading with auto precharge moves bank n to precharging on that same clock. Bank n's data continues until bank m's first slot, which arrives CL after bank m's read.
- R8: A write to another bank ends a read at once. No further slots come from that read, including ones still in the latency pipeline. The interrupted bank moves on that same clock: to precharging if auto precharge was set, otherwise to active.
- R9: A write registered at clock T while a read is in flight needs `dqm_i`=1 at clock T-3. If it was 0, `viol_o` is 1 for one cycle after T, and the write still proceeds.
- R10: A precharging bank stays in that state for T_RP cycles and then becomes idle. A read with auto precharge that is not interrupted starts precharging after its last data slot.
- R11: A write with auto precharge spends T_DPL cycles in write-back after its last accept slot, then precharges.
- R12: Activate to a bank that is not idle, or read or write to an idle, precharging or write-back bank, sets `viol_o` for one cycle. The command is dropped: no state change and no slots.
- R13: Read slots and write accept slots never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge |
| ap_i | input | 1 | Auto precharge with a read or write |
| bank_i | input | 2 | Target bank |
| col_i | input | COL_W | Start column of a read or write |
| dqm_i | input | 1 | Data mask input, sampled each clock |
| bl_code_i | input | 2 | Burst length code, length = 2^code |
| cl_i | input | 2 | CAS latency in clocks |
| wbm_i | input | 1 | Write burst mode: 1 forces single-column writes |
| rd_valid_o | output | 1 | Read data slot valid |
| rd_bank_o | output | 2 | Bank of the current read slot |
| rd_col_o | output | COL_W | Column of the current read slot |
| wr_acc_o | output | 1 | Write data accepted this cycle |
| wr_bank_o | output | 2 | Bank of the current write slot |
| wr_col_o | output | COL_W | Column of the current write slot |
| bank_state_o | output | 12 | Four 3-bit bank states |
| viol_o | output | 1 | Protocol violation pulse |

## Verification
A wrong bank state shows up on `bank_state_o` in the cycle after the clock that caused it. It then shows up a second time through `viol_o` or through dropped slots when the next command to that bank is judged legal or illegal. Errors in the latency pipeline or the burst counter show up as slots that come one or more cycles early or late, or with a wrong column. The bench therefore checks every beat of each burst in its exact cycle. Precharge and write-back counter errors change the cycle in which a bank reads idle, so the bench samples the cycles on both sides of each expected transition.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  localparam int BANK_W    = 2;
  localparam int NUM_BANKS = 1 << BANK_W;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    BS_IDLE   = 3'd0,
    BS_ACTIVE = 3'd1,
    BS_READ   = 3'd2,
    BS_WRITE  = 3'd3,
    BS_WBACK  = 3'd4,
    BS_PRECH  = 3'd5
  } bank_st_e;
endpackage

// File: rtl/sdram_burst_ctr.sv
module sdram_burst_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             kill_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       blc_i,
  output logic             valid_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  logic [3:0]       len;
  logic [COL_W-1:0] mask_in;
  logic             valid_q;
  logic [COL_W-1:0] col_q, mask_q;
  logic [3:0]       rem_q;

  assign len     = 4'd1 << blc_i;
  assign mask_in = COL_W'(len - 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      col_q   <= '0;
      mask_q  <= '0;
      rem_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      col_q   <= col_i;
      mask_q  <= mask_in;
      rem_q   <= len - 4'd1;
    end else if (kill_i) begin
      valid_q <= 1'b0;
    end else if (valid_q) begin
      if (rem_q == 4'd0) begin
        valid_q <= 1'b0;
      end else begin
        col_q <= (col_q & ~mask_q) | ((col_q + 1'b1) & mask_q);
        rem_q <= rem_q - 4'd1;
      end
    end
  end

  assign valid_o = valid_q;
  assign col_o   = col_q;
  assign last_o  = valid_q && (rem_q == 4'd0);

  // R4: a continuing burst never leaves its aligned column block
  p_wrap_in_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !load_i && !kill_i && rem_q != 4'd0) |=>
      ((col_q & ~mask_q) == ($past(col_q) & ~$past(mask_q))));
endmodule

// File: rtl/sdram_rd_path.sv
module sdram_rd_path
  import sdram_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 kill_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [COL_W-1:0]     col_i,
  input  logic [1:0]           blc_i,
  input  logic [1:0]           cl_i,
  output logic                 valid_o,
  output logic [BANK_W-1:0]    bank_o,
  output logic [COL_W-1:0]     col_o,
  output logic                 last_o,
  output logic                 busy_o,
  output logic [NUM_BANKS-1:0] pend_o
);
  localparam int DEPTH = 3;

  typedef struct packed {
    logic              v;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
    logic [1:0]        blc;
  } rd_req_t;

  rd_req_t           pipe_q [DEPTH];
  logic [1:0]        tap;
  logic              launch;
  logic [BANK_W-1:0] bank_q;

  assign tap    = (cl_i == 2'd0) ? 2'd0 : cl_i - 2'd1;
  assign launch = pipe_q[tap].v && !kill_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
      bank_q <= '0;
    end else begin
      pipe_q[0] <= '{v: start_i && !kill_i, bank: bank_i, col: col_i, blc: blc_i};
      for (int i = 1; i < DEPTH; i++) begin
        pipe_q[i] <= pipe_q[i-1];
        if (kill_i || (i - 1) == int'(tap)) pipe_q[i].v <= 1'b0;
      end
      if (launch) bank_q <= pipe_q[tap].bank;
    end
  end

  sdram_burst_ctr #(.COL_W(COL_W)) i_rd_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (launch),
    .kill_i  (kill_i),
    .col_i   (pipe_q[tap].col),
    .blc_i   (pipe_q[tap].blc),
    .valid_o (valid_o),
    .col_o   (col_o),
    .last_o  (last_o)
  );

  assign bank_o = bank_q;

  always_comb begin
    pend_o = '0;
    busy_o = valid_o;
    for (int i = 0; i < DEPTH; i++) begin
      if (pipe_q[i].v) begin
        pend_o[pipe_q[i].bank] = 1'b1;
        busy_o = 1'b1;
      end
    end
  end

  // R8: a kill leaves no read slot in the following cycle
  p_kill_stops_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> !valid_o);
endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_seq_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_DPL = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     act_i,
  input  logic     rd_i,
  input  logic     wr_i,
  input  logic     ap_i,
  input  logic     pre_i,
  input  logic     other_i,
  input  logic     rd_done_i,
  input  logic     wr_done_i,
  output bank_st_e state_o
);
  localparam int CNT_MAX = (T_RP > T_DPL) ? T_RP : T_DPL;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  bank_st_e         state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= BS_IDLE;
      cnt_q   <= '0;
      ap_q    <= 1'b0;
    end else if (pre_i && state_q != BS_IDLE && state_q != BS_PRECH) begin
      state_q <= BS_PRECH;
      cnt_q   <= CNT_W'(T_RP);
    end else if (act_i) begin
      state_q <= BS_ACTIVE;
    end else if (rd_i || wr_i) begin
      state_q <= rd_i ? BS_READ : BS_WRITE;
      ap_q    <= ap_i;
    end else begin
      unique case (state_q)
        BS_READ: if (other_i || rd_done_i) begin
          state_q <= ap_q ? BS_PRECH : BS_ACTIVE;
          cnt_q   <= CNT_W'(T_RP);
        end
        BS_WRITE: if (other_i || wr_done_i) begin
          state_q <= ap_q ? BS_WBACK : BS_ACTIVE;
          cnt_q   <= CNT_W'(T_DPL);
        end
        BS_WBACK: if (cnt_q == CNT_W'(1)) begin
          state_q <= BS_PRECH;
          cnt_q   <= CNT_W'(T_RP);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        BS_PRECH: if (cnt_q == CNT_W'(1)) begin
          state_q <= BS_IDLE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign state_o = state_q;

  // R10: idle is only ever entered from precharging
  p_idle_from_prech_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BS_IDLE && $past(state_q) != BS_IDLE) |-> $past(state_q) == BS_PRECH);
  // R11: write-back always hands over to precharging
  p_wback_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == BS_WBACK && state_q != BS_WBACK) |-> state_q == BS_PRECH);
endmodule

// File: rtl/sdram_ap_sequencer.sv
module sdram_ap_sequencer
  import sdram_seq_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int T_RP  = 3,
  parameter int T_DPL = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         cmd_i,
  input  logic               ap_i,
  input  logic [1:0]         bank_i,
  input  logic [COL_W-1:0]   col_i,
  input  logic               dqm_i,
  input  logic [1:0]         bl_code_i,
  input  logic [1:0]         cl_i,
  input  logic               wbm_i,
  output logic               rd_valid_o,
  output logic [1:0]         rd_bank_o,
  output logic [COL_W-1:0]   rd_col_o,
  output logic               wr_acc_o,
  output logic [1:0]         wr_bank_o,
  output logic [COL_W-1:0]   wr_col_o,
  output logic [3*NUM_BANKS-1:0] bank_state_o,
  output logic               viol_o
);
  cmd_e           cmd;
  bank_st_e       st [NUM_BANKS];
  bank_st_e       sel_st;
  logic           acc_ok, rd_go, wr_go, act_go, pre_go;
  logic           rd_busy, rd_last, wr_last, dqm_miss, viol_d, viol_q;
  logic [2:0]     dqm_hist_q;
  logic [NUM_BANKS-1:0] rd_pend;
  logic [BANK_W-1:0]    wr_bank_q;

  assign cmd    = cmd_e'(cmd_i);
  assign sel_st = st[bank_i];
  assign acc_ok = (sel_st == BS_ACTIVE) || (sel_st == BS_READ) || (sel_st == BS_WRITE);
  assign rd_go  = (cmd == CMD_RD) && acc_ok;
  assign wr_go  = (cmd == CMD_WR) && acc_ok;
  assign act_go = (cmd == CMD_ACT) && (sel_st == BS_IDLE);
  assign pre_go = (cmd == CMD_PRE);

  assign dqm_miss = wr_go && rd_busy && !dqm_hist_q[2];
  assign viol_d   = ((cmd == CMD_ACT) && (sel_st != BS_IDLE))
                 || (((cmd == CMD_RD) || (cmd == CMD_WR)) && !acc_ok)
                 || dqm_miss;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dqm_hist_q <= '0;
      viol_q     <= 1'b0;
      wr_bank_q  <= '0;
    end else begin
      dqm_hist_q <= {dqm_hist_q[1:0], dqm_i};
      viol_q     <= viol_d;
      if (wr_go) wr_bank_q <= bank_i;
    end
  end

  sdram_rd_path #(.COL_W(COL_W)) i_rd_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (rd_go),
    .kill_i  (wr_go),
    .bank_i  (bank_i),
    .col_i   (col_i),
    .blc_i   (bl_code_i),
    .cl_i    (cl_i),
    .valid_o (rd_valid_o),
    .bank_o  (rd_bank_o),
    .col_o   (rd_col_o),
    .last_o  (rd_last),
    .busy_o  (rd_busy),
    .pend_o  (rd_pend)
  );

  sdram_burst_ctr #(.COL_W(COL_W)) i_wr_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (wr_go),
    .kill_i  (rd_go),
    .col_i   (col_i),
    .blc_i   (wbm_i ? 2'd0 : bl_code_i),
    .valid_o (wr_acc_o),
    .col_o   (wr_col_o),
    .last_o  (wr_last)
  );

  assign wr_bank_o = wr_bank_q;
  assign viol_o    = viol_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_i == BANK_W'(b));

    sdram_bank_fsm #(.T_RP(T_RP), .T_DPL(T_DPL)) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_i     (act_go && hit),
      .rd_i      (rd_go && hit),
      .wr_i      (wr_go && hit),
      .ap_i      (ap_i),
      .pre_i     (pre_go && hit),
      .other_i   ((rd_go || wr_go) && !hit),
      .rd_done_i (rd_last && rd_bank_o == BANK_W'(b) && !rd_pend[b]),
      .wr_done_i (wr_last && wr_bank_q == BANK_W'(b)),
      .state_o   (st[b])
    );
    assign bank_state_o[3*b +: 3] = st[b];
  end

  // R13: read and write slots are exclusive
  p_bus_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid_o && wr_acc_o));
  // R12: activating a busy bank is flagged
  p_act_busy_viol_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT && sel_st != BS_IDLE) |=> viol_o);
  // R5: single-column write in write burst mode
  p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && wbm_i) |=> wr_acc_o ##1 (!wr_acc_o || $past(wr_go)));
  // R6: a legal write is accepted in the next cycle
  p_wr_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> wr_acc_o);
endmodule

// File: tb/test_sdram_ap_sequencer.sv
module test_sdram_ap_sequencer;
  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       cmd = 3'd0;
  logic             ap = 1'b0;
  logic [1:0]       bank = 2'd0;
  logic [COL_W-1:0] col = '0;
  logic             dqm = 1'b0;
  logic [1:0]       blc = 2'd2;
  logic [1:0]       cl = 2'd3;
  logic             wbm = 1'b0;

  logic             rd_valid, wr_acc, viol;
  logic [1:0]       rd_bank, wr_bank;
  logic [COL_W-1:0] rd_col, wr_col;
  logic [11:0]      bstate;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  sdram_ap_sequencer #(.COL_W(COL_W), .T_RP(3), .T_DPL(2)) i_sdram_ap_sequencer (
    .clk (clk), .rst_n (rst_n), .cmd_i (cmd), .ap_i (ap), .bank_i (bank),
    .col_i (col), .dqm_i (dqm), .bl_code_i (blc), .cl_i (cl), .wbm_i (wbm),
    .rd_valid_o (rd_valid), .rd_bank_o (rd_bank), .rd_col_o (rd_col),
    .wr_acc_o (wr_acc), .wr_bank_o (wr_bank), .wr_col_o (wr_col),
    .bank_state_o (bstate), .viol_o (viol)
  );

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  function automatic logic [2:0] st(input int b);
    return bstate[3*b +: 3];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; command registered at the next rising edge
  task automatic issue(input logic [2:0] c, input logic a, input logic [1:0] b,
                       input logic [COL_W-1:0] cc);
    cmd = c; ap = a; bank = b; col = cc;
    @(negedge clk);
    cmd = NOP; ap = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 bank states", 32'(bstate), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    chk("R1 wr_acc", 32'(wr_acc), 0);
    chk("R1 viol", 32'(viol), 0);
  endtask

  task automatic t_basic_read;
    issue(ACT, 0, 2'd0, 0);
    chk("R2 activate", 32'(st(0)), 1);
    issue(RD, 0, 2'd0, 8'h05);
    chk("R2 reading", 32'(st(0)), 2);
    step(2);
    chk("R3 not early", 32'(rd_valid), 0);
    step(1);
    chk("R3 first slot", 32'(rd_valid), 1);
    chk("R3 first col", 32'(rd_col), 32'h05);
    step(1); chk("R4 col beat1", 32'(rd_col), 32'h06);
    step(1); chk("R4 col beat2", 32'(rd_col), 32'h07);
    step(1); chk("R4 wrap beat3", 32'(rd_col), 32'h04);
    chk("R3 beat3 valid", 32'(rd_valid), 1);
    step(1);
    chk("R3 burst ends", 32'(rd_valid), 0);
    chk("R2 back to active", 32'(st(0)), 1);
  endtask

  task automatic t_rd_int_rd;
    issue(ACT, 0, 2'd1, 0);
    issue(ACT, 0, 2'd2, 0);
    issue(RD, 1, 2'd1, 8'h00);
    step(1);
    issue(RD, 0, 2'd2, 8'h08);
    chk("R7 bank n precharging", 32'(st(1)), 5);
    chk("R7 bank m reading", 32'(st(2)), 2);
    step(1);
    chk("R7 old data bank", 32'(rd_bank), 1);
    chk("R7 old data col0", 32'(rd_col), 0);
    step(1);
    chk("R7 old data col1", 32'(rd_col), 1);
    chk("R10 still precharging", 32'(st(1)), 5);
    step(1);
    chk("R7 new bank takes over", 32'(rd_bank), 2);
    chk("R7 new col", 32'(rd_col), 32'h08);
    chk("R10 idle after tRP", 32'(st(1)), 0);
    step(3);
    chk("R7 new last col", 32'(rd_col), 32'h0B);
    step(1);
    chk("R3 read ends", 32'(rd_valid), 0);
    chk("R2 bank m active", 32'(st(2)), 1);
  endtask

  task automatic t_rd_int_wr;
    dqm = 1'b1;
    issue(ACT, 0, 2'd1, 0);
    issue(RD, 1, 2'd0, 8'h10);
    step(1);
    issue(WR, 0, 2'd1, 8'h20);
    dqm = 1'b0;
    chk("R8 bank n precharging", 32'(st(0)), 5);
    chk("R8 bank m writing", 32'(st(1)), 3);
    chk("R9 dqm honoured no viol", 32'(viol), 0);
    chk("R6 accept at once", 32'(wr_acc), 1);
    chk("R6 first write col", 32'(wr_col), 32'h20);
    chk("R6 write bank", 32'(wr_bank), 1);
    step(1);
    chk("R8 no read slot", 32'(rd_valid), 0);
    chk("R13 write only", 32'(wr_acc), 1);
    chk("R6 col beat1", 32'(wr_col), 32'h21);
    step(2);
    chk("R6 col beat3", 32'(wr_col), 32'h23);
    chk("R10 bank n idle", 32'(st(0)), 0);
    step(1);
    chk("R6 write ends", 32'(wr_acc), 0);
    chk("R2 writer active", 32'(st(1)), 1);
  endtask

  task automatic t_dqm_miss;
    issue(RD, 0, 2'd2, 8'h00);
    step(1);
    issue(WR, 0, 2'd1, 8'h00);
    chk("R9 viol raised", 32'(viol), 1);
    chk("R9 write proceeds", 32'(wr_acc), 1);
    chk("R8 non-ap read to active", 32'(st(2)), 1);
    step(1);
    chk("R9 viol one cycle", 32'(viol), 0);
    step(3);
    chk("R6 write done", 32'(wr_acc), 0);
  endtask

  task automatic t_single_write;
    int cnt;
    wbm = 1'b1;
    issue(WR, 1, 2'd1, 8'h03);
    chk("R5 single slot", 32'(wr_acc), 1);
    chk("R5 col", 32'(wr_col), 32'h03);
    step(1);
    chk("R5 only one slot", 32'(wr_acc), 0);
    chk("R11 write-back", 32'(st(1)), 4);
    step(1);
    chk("R11 write-back tDPL", 32'(st(1)), 4);
    step(1);
    chk("R11 then precharge", 32'(st(1)), 5);
    step(2);
    chk("R10 precharge tRP", 32'(st(1)), 5);
    step(1);
    chk("R10 idle", 32'(st(1)), 0);
    issue(RD, 0, 2'd2, 8'h04);
    step(2);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      step(1);
      if (rd_valid) cnt++;
    end
    chk("R5 reads keep burst length", 32'(cnt), 4);
    wbm = 1'b0;
  endtask

  task automatic t_illegal;
    int seen;
    issue(RD, 0, 2'd1, 8'h00);
    chk("R12 read idle viol", 32'(viol), 1);
    chk("R12 state unchanged", 32'(st(1)), 0);
    seen = 0;
    for (int i = 0; i < 5; i++) begin
      step(1);
      if (rd_valid) seen++;
    end
    chk("R12 no slots from dropped read", 32'(seen), 0);
    issue(ACT, 0, 2'd2, 0);
    chk("R12 act busy viol", 32'(viol), 1);
    chk("R12 act busy state", 32'(st(2)), 1);
    issue(PRE, 0, 2'd2, 0);
    chk("R2 precharge cmd", 32'(st(2)), 5);
    chk("R12 precharge legal", 32'(viol), 0);
    step(3);
    chk("R10 idle after precharge", 32'(st(2)), 0);
  endtask

  task automatic t_bl8_cl2_ap;
    logic [COL_W-1:0] exp_col [8] = '{8'h0D, 8'h0E, 8'h0F, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C};
    blc = 2'd3; cl = 2'd2;
    issue(ACT, 0, 2'd3, 0);
    issue(RD, 1, 2'd3, 8'h0D);
    step(1);
    chk("R3 cl2 not early", 32'(rd_valid), 0);
    for (int i = 0; i < 8; i++) begin
      step(1);
      chk("R3 cl2 bl8 valid", 32'(rd_valid), 1);
      chk("R4 bl8 wrap col", 32'(rd_col), 32'(exp_col[i]));
    end
    step(1);
    chk("R3 bl8 ends", 32'(rd_valid), 0);
    chk("R10 ap read precharges", 32'(st(3)), 5);
    step(3);
    chk("R10 ap read idle", 32'(st(3)), 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_basic_read();
    t_rd_int_rd();
    t_rd_int_wr();
    t_dqm_miss();
    t_single_write();
    t_illegal();
    t_bl8_cl2_ap();
    step(2);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule